// File: doc/BRIEF.md
# USB Device Reset Sequencing Controller

This block owns the power-on state of a USB peripheral controller core and decides when its embedded CPU may run. A synchronous power-on reset loads every piece of core control state with its start-up value and leaves the CPU held. The CPU is let go by one of three events. A host write can clear the CPU hold bit, which is the last step of a RAM download. The EEPROM loader can report that it has finished. The external-ROM strap can be high in the first cycle after power-on reset.

While the CPU is held, the block answers every bulk token from the host with NAK, and it ignores all CPU register writes. Once the CPU runs, the OUT endpoints are enabled. Bulk tokens are then answered from the arm and stall state, and the CPU can program the endpoint and control state through a small write-only register map. Isochronous IN tokens follow a no-load policy: an endpoint that was not loaded gets either no response or a zero-length reply. Which of the two is chosen by a mode bit that is clear after power-on reset.

Top module: `usb_rst_seq`

## Requirements
- R1: During and directly after `por`, the outputs are as follows. `cpu_reset` is 1. `hs_valid` is 0. `out_ep_en`, `in_armed`, `ep_stall`, `ep_toggle`, `int_en`, `int_req`, `func_addr`, `cfg_num` and `alt_set` are all 0. `usb_irq`, `req_to_cpu`, `pair_en`, `autovec_en` and `iso_send0` are all 0. Every isochronous loaded flag is cleared.
- R2: `rom_strap` is sampled only in the first cycle after `por` falls. If it is high then, `cpu_reset` drops one clock later. At any other time `rom_strap` has no effect.
- R3: A `host_ctl_wr` with `host_ctl_val`=0 releases the CPU: `cpu_reset` is 0 after the next clock edge. When `host_ctl_wr` is present, it takes priority over `eeprom_done` in the same cycle.
- R4: An `eeprom_done` pulse releases the CPU if it arrives while the CPU is held, including in the first cycle after `por`.
- R5: Once released, the CPU stays released. The only ways to hold it again are a `host_ctl_wr` with `host_ctl_val`=1, which sets `cpu_reset` after the next edge, or a new `por`. `eeprom_done` has no effect while the CPU runs.
- R6: While `cpu_reset` is 1, two rules hold. Every bulk token (endpoint number below NUM_BULK, which is 8 by default) gets a NAK. Every `cpu_wr` is ignored, so no control output changes.
- R7: `out_ep_en` is all ones in exactly the cycles in which `cpu_reset` is 0. In every other cycle it is all zeros.
- R8: Every `tok_valid` cycle gives `hs_valid`=1 one clock later. The accompanying `hs_code` uses these codes: 2'b00 for no response, 2'b01 for NAK, 2'b10 for ACK and 2'b11 for STALL. When there is no token, `hs_valid` is 0 and `hs_code` is 2'b00.
- R9: With the CPU running, bulk tokens are answered as follows:
  - a stalled endpoint gets STALL;
  - an IN token (`tok_in`=1) on an armed endpoint gets ACK and disarms that endpoint;
  - an IN token on an unarmed endpoint gets NAK;
  - an OUT token gets ACK.

  Every bulk ACK flips that endpoint's `ep_toggle` bit and sets its `int_req` bit.
- R10: An isochronous endpoint is endpoint NUM_BULK+j, and its loaded flag is j. An IN token on it is answered as follows:
  - if flag j is set, the answer is ACK and the flag is cleared;
  - if flag j is clear and `iso_send0`=0, there is no response (2'b00);
  - if flag j is clear and `iso_send0`=1, the answer is ACK.

  Isochronous OUT tokens always get no response.
- R11: `cpu_wr` takes effect only while the CPU runs. It uses the address `cpu_waddr` and the data `cpu_wdata`:
  - address 0 ORs the data into `in_armed`;
  - address 1 writes `ep_stall`;
  - address 3 writes `func_addr` from data[6:0];
  - address 4 writes `int_en`;
  - address 6 writes the mode bits from data[3:0], where bit0 is `req_to_cpu`, bit1 is `pair_en`, bit2 is `autovec_en` and bit3 is `iso_send0`;
  - address 7 writes `cfg_num` from data[3:0] and `alt_set` from data[7:4];
  - address 8 ORs the data into the isochronous loaded flags.
- R12: `req_to_cpu` is 0 after `por`, so the core answers device requests itself. A CPU write to address 6 with bit0 set routes device requests to the CPU.
- R13: `usb_irq` is 1 exactly when `int_req & int_en` is not zero.
- R14: Two addresses clear state. A write to address 2 clears every `ep_toggle` bit that is set in the data. A write to address 5 clears every `int_req` bit that is set in the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por | input | 1 | Synchronous power-on reset, active high |
| host_ctl_wr | input | 1 | Host write strobe to the CPU hold bit |
| host_ctl_val | input | 1 | Value written to the CPU hold bit (1 = hold) |
| eeprom_done | input | 1 | EEPROM load finished pulse |
| rom_strap | input | 1 | External-ROM strap |
| tok_valid | input | 1 | Host token present this cycle |
| tok_in | input | 1 | Token direction, 1 = IN, 0 = OUT |
| tok_ep | input | EP_W (4) | Token endpoint number |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_waddr | input | 4 | CPU register address |
| cpu_wdata | input | DATA_W (8) | CPU register write data |
| cpu_reset | output | 1 | CPU reset, 1 = held |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | Handshake code |
| out_ep_en | output | NUM_BULK (8) | OUT endpoint enables |
| in_armed | output | NUM_BULK (8) | IN endpoint armed flags |
| ep_stall | output | NUM_BULK (8) | Endpoint stall bits |
| ep_toggle | output | NUM_BULK (8) | Endpoint data toggle bits |
| func_addr | output | FADDR_W (7) | USB function address |
| int_en | output | NUM_BULK (8) | Interrupt enables per endpoint |
| int_req | output | NUM_BULK (8) | Pending interrupt requests |
| usb_irq | output | 1 | Combined interrupt to the CPU |
| req_to_cpu | output | 1 | Device requests routed to the CPU |
| pair_en | output | 1 | Endpoint pairing enable |
| autovec_en | output | 1 | Interrupt autovectoring enable |
| iso_send0 | output | 1 | Zero-length reply for unloaded isochronous IN |
| cfg_num | output | CFG_W (4) | Active configuration number |
| alt_set | output | CFG_W (4) | Active alternate setting |

## Verification
The release paths are each tried on their own: the strap at boot, `eeprom_done` while held, and a host write of 0. The bench then tries them where they should do nothing: `eeprom_done` and the strap while the CPU runs, and the strap after a host write of 1. These cases separate a correct one-shot strap sample from a level-sensitive one, and a sticky release from one that can be undone. Directed token sequences cover every handshake path, run on both a held and a running CPU: stall, armed IN, unarmed IN, OUT, and an isochronous endpoint that is loaded, unloaded with the mode bit clear, or unloaded with it set. These cases separate the handshake priorities, and they show the state side effects of disarming, toggle flips and interrupt requests. A seeded random mix of tokens, register writes, host writes and EEPROM pulses then checks every output, every cycle, against a bench model. This finds ordering errors between the arm, toggle, interrupt and loaded-flag updates that the directed cases miss.

// File: rtl/usb_rst_pkg.sv
package usb_rst_pkg;

    localparam int REG_AW = 4;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_NAK   = 2'b01,
        HS_ACK   = 2'b10,
        HS_STALL = 2'b11
    } hs_e;

    typedef enum logic [1:0] {
        CS_BOOT = 2'd0,
        CS_HELD = 2'd1,
        CS_RUN  = 2'd2
    } cpu_st_e;

    typedef enum logic [REG_AW-1:0] {
        RA_ARM_IN  = 4'd0,
        RA_STALL   = 4'd1,
        RA_TOG_CLR = 4'd2,
        RA_FADDR   = 4'd3,
        RA_INT_EN  = 4'd4,
        RA_INT_CLR = 4'd5,
        RA_MODE    = 4'd6,
        RA_CFG     = 4'd7,
        RA_ISO_LD  = 4'd8
    } reg_addr_e;

    // renum sits in bit 0 so a cast from write data [3:0] lines up
    typedef struct packed {
        logic iso_send0;
        logic autovec;
        logic pairing;
        logic renum;
    } mode_t;

    localparam mode_t MODE_POR = '{iso_send0: 1'b0, autovec: 1'b0,
                                   pairing: 1'b0, renum: 1'b0};

    // Reply to a bulk token from hold, stall and arm state
    function automatic hs_e bulk_reply(input logic held, input logic stalled,
                                       input logic dir_in, input logic armed);
        if (held)
            return HS_NAK;
        else if (stalled)
            return HS_STALL;
        else if (dir_in)
            return armed ? HS_ACK : HS_NAK;
        else
            return HS_ACK;
    endfunction

    // Reply to an isochronous IN token
    function automatic hs_e iso_in_reply(input logic loaded, input logic send0);
        if (loaded || send0)
            return HS_ACK;
        else
            return HS_NONE;
    endfunction

endpackage

// File: rtl/usb_rst_cpu_hold.sv
module usb_rst_cpu_hold
    import usb_rst_pkg::*;
(
    input  logic clk,
    input  logic por,
    input  logic host_wr,
    input  logic host_val,
    input  logic eeprom_done,
    input  logic rom_strap,
    output logic cpu_held
);

    cpu_st_e st_q;
    cpu_st_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CS_BOOT: begin
                if (host_wr)
                    st_d = host_val ? CS_HELD : CS_RUN;
                else if (rom_strap || eeprom_done)
                    st_d = CS_RUN;
                else
                    st_d = CS_HELD;
            end
            CS_HELD: begin
                if (host_wr)
                    st_d = host_val ? CS_HELD : CS_RUN;
                else if (eeprom_done)
                    st_d = CS_RUN;
            end
            CS_RUN: begin
                if (host_wr && host_val)
                    st_d = CS_HELD;
            end
            default: st_d = CS_HELD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por)
            st_q <= CS_BOOT;
        else
            st_q <= st_d;
    end

    assign cpu_held = (st_q != CS_RUN);

    // R5: a running CPU stays running unless the host sets the hold bit
    assert_stay_run_R5: assert property (@(posedge clk) disable iff (por)
        (!cpu_held && !(host_wr && host_val)) |=> !cpu_held);

    // R5: a host write of 1 always holds the CPU
    assert_rehold_R5: assert property (@(posedge clk) disable iff (por)
        (host_wr && host_val) |=> cpu_held);

    // R2: outside boot, a held CPU ignores the strap
    assert_strap_once_R2: assert property (@(posedge clk) disable iff (por)
        (st_q == CS_HELD && !host_wr && !eeprom_done) |=> cpu_held);

    // R4: the EEPROM pulse releases a held CPU when the host is silent
    assert_eeprom_release_R4: assert property (@(posedge clk) disable iff (por)
        (cpu_held && !host_wr && eeprom_done) |=> !cpu_held);

endmodule

// File: rtl/usb_rst_responder.sv
module usb_rst_responder
    import usb_rst_pkg::*;
#(
    parameter int NUM_BULK = 8,
    parameter int NUM_ISO  = 8,
    parameter int EP_W     = 4
) (
    input  logic                clk,
    input  logic                por,
    input  logic                cpu_held,
    input  logic                tok_valid,
    input  logic                tok_in,
    input  logic [EP_W-1:0]     tok_ep,
    input  logic [NUM_BULK-1:0] ep_stall,
    input  logic [NUM_BULK-1:0] in_armed,
    input  logic [NUM_ISO-1:0]  iso_loaded,
    input  logic                iso_send0,
    output logic                hs_valid,
    output hs_e                 hs_code,
    output logic [NUM_BULK-1:0] ack_mask,
    output logic [NUM_BULK-1:0] in_take,
    output logic [NUM_ISO-1:0]  iso_take
);

    hs_e  code_d;
    logic bulk_hit;

    assign bulk_hit = (int'(tok_ep) < NUM_BULK);

    always_comb begin
        code_d   = HS_NONE;
        ack_mask = '0;
        in_take  = '0;
        iso_take = '0;
        if (tok_valid) begin
            for (int i = 0; i < NUM_BULK; i++) begin
                if (tok_ep == EP_W'(i)) begin
                    code_d = bulk_reply(cpu_held, ep_stall[i], tok_in, in_armed[i]);
                    if (code_d == HS_ACK) begin
                        ack_mask[i] = 1'b1;
                        in_take[i]  = tok_in;
                    end
                end
            end
            for (int j = 0; j < NUM_ISO; j++) begin
                if (tok_ep == EP_W'(NUM_BULK + j)) begin
                    if (tok_in) begin
                        code_d      = iso_in_reply(iso_loaded[j], iso_send0);
                        iso_take[j] = iso_loaded[j];
                    end else begin
                        code_d = HS_NONE;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (por) begin
            hs_valid <= 1'b0;
            hs_code  <= HS_NONE;
        end else begin
            hs_valid <= tok_valid;
            hs_code  <= code_d;
        end
    end

    // R6: bulk tokens seen while the CPU is held are answered with NAK
    assert_held_nak_R6: assert property (@(posedge clk) disable iff (por)
        (tok_valid && cpu_held && bulk_hit) |=> (hs_code == HS_NAK));

    // R8: a decision appears exactly one cycle after each token
    assert_hs_latency_R8: assert property (@(posedge clk) disable iff (por)
        tok_valid |=> hs_valid);

    assert_hs_idle_R8: assert property (@(posedge clk) disable iff (por)
        !tok_valid |=> (!hs_valid && hs_code == HS_NONE));

    // R10: isochronous OUT tokens never draw a handshake
    assert_iso_out_silent_R10: assert property (@(posedge clk) disable iff (por)
        (tok_valid && !tok_in && !bulk_hit) |=> (hs_code == HS_NONE));

endmodule

// File: rtl/usb_rst_ctrl_regs.sv
module usb_rst_ctrl_regs
    import usb_rst_pkg::*;
#(
    parameter int NUM_BULK = 8,
    parameter int NUM_ISO  = 8,
    parameter int DATA_W   = 8,
    parameter int FADDR_W  = 7,
    parameter int CFG_W    = 4
) (
    input  logic                clk,
    input  logic                por,
    input  logic                cpu_held,
    input  logic                cpu_wr,
    input  logic [REG_AW-1:0]   cpu_waddr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    input  logic [NUM_BULK-1:0] ack_mask,
    input  logic [NUM_BULK-1:0] in_take,
    input  logic [NUM_ISO-1:0]  iso_take,
    output logic [NUM_BULK-1:0] in_armed,
    output logic [NUM_BULK-1:0] ep_stall,
    output logic [NUM_BULK-1:0] ep_toggle,
    output logic [NUM_BULK-1:0] int_en,
    output logic [NUM_BULK-1:0] int_req,
    output logic [NUM_ISO-1:0]  iso_loaded,
    output logic [FADDR_W-1:0]  func_addr,
    output mode_t               mode,
    output logic [CFG_W-1:0]    cfg_num,
    output logic [CFG_W-1:0]    alt_set
);

    logic      wr_ok;
    reg_addr_e wsel;
    logic [NUM_BULK-1:0] arm_set, tog_clr, req_clr;
    logic [NUM_ISO-1:0]  iso_set;

    assign wr_ok = cpu_wr && !cpu_held;
    assign wsel  = reg_addr_e'(cpu_waddr);

    assign arm_set = (wr_ok && wsel == RA_ARM_IN)  ? cpu_wdata[NUM_BULK-1:0] : '0;
    assign tog_clr = (wr_ok && wsel == RA_TOG_CLR) ? cpu_wdata[NUM_BULK-1:0] : '0;
    assign req_clr = (wr_ok && wsel == RA_INT_CLR) ? cpu_wdata[NUM_BULK-1:0] : '0;
    assign iso_set = (wr_ok && wsel == RA_ISO_LD)  ? cpu_wdata[NUM_ISO-1:0]  : '0;

    // Per-endpoint state that both the CPU and token traffic touch
    always_ff @(posedge clk) begin
        if (por) begin
            in_armed   <= '0;
            ep_toggle  <= '0;
            int_req    <= '0;
            iso_loaded <= '0;
        end else begin
            in_armed   <= (in_armed & ~in_take) | arm_set;
            ep_toggle  <= (ep_toggle ^ ack_mask) & ~tog_clr;
            int_req    <= (int_req & ~req_clr) | ack_mask;
            iso_loaded <= (iso_loaded & ~iso_take) | iso_set;
        end
    end

    // State that only the CPU writes
    always_ff @(posedge clk) begin
        if (por) begin
            ep_stall  <= '0;
            int_en    <= '0;
            func_addr <= '0;
            mode      <= MODE_POR;
            cfg_num   <= '0;
            alt_set   <= '0;
        end else if (wr_ok) begin
            unique case (wsel)
                RA_STALL:  ep_stall  <= cpu_wdata[NUM_BULK-1:0];
                RA_INT_EN: int_en    <= cpu_wdata[NUM_BULK-1:0];
                RA_FADDR:  func_addr <= cpu_wdata[FADDR_W-1:0];
                RA_MODE:   mode      <= mode_t'(cpu_wdata[3:0]);
                RA_CFG: begin
                    cfg_num <= cpu_wdata[CFG_W-1:0];
                    alt_set <= cpu_wdata[2*CFG_W-1:CFG_W];
                end
                default: ;
            endcase
        end
    end

    // R6: a held CPU cannot move any control state through writes or traffic
    assert_held_freeze_R6: assert property (@(posedge clk) disable iff (por)
        cpu_held |=> ($stable(func_addr) && $stable(ep_stall) && $stable(mode) &&
                      $stable(cfg_num) && $stable(alt_set) && $stable(int_en) &&
                      $stable(in_armed) && $stable(ep_toggle)));

    // R9: an IN acknowledgement leaves its endpoint disarmed
    assert_in_disarm_R9: assert property (@(posedge clk) disable iff (por)
        ((in_take != '0) && !wr_ok) |=> ((in_armed & $past(in_take)) == '0));

    // R9: every bulk ACK leaves an interrupt request pending
    assert_ack_irq_R9: assert property (@(posedge clk) disable iff (por)
        (ack_mask != '0) |=> ((int_req & $past(ack_mask)) == $past(ack_mask)));

endmodule

// File: rtl/usb_rst_seq.sv
module usb_rst_seq
    import usb_rst_pkg::*;
#(
    parameter int NUM_BULK = 8,
    parameter int NUM_ISO  = 8,
    parameter int EP_W     = 4,
    parameter int DATA_W   = 8,
    parameter int FADDR_W  = 7,
    parameter int CFG_W    = 4
) (
    input  logic                clk,
    input  logic                por,
    input  logic                host_ctl_wr,
    input  logic                host_ctl_val,
    input  logic                eeprom_done,
    input  logic                rom_strap,
    input  logic                tok_valid,
    input  logic                tok_in,
    input  logic [EP_W-1:0]     tok_ep,
    input  logic                cpu_wr,
    input  logic [REG_AW-1:0]   cpu_waddr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic                cpu_reset,
    output logic                hs_valid,
    output logic [1:0]          hs_code,
    output logic [NUM_BULK-1:0] out_ep_en,
    output logic [NUM_BULK-1:0] in_armed,
    output logic [NUM_BULK-1:0] ep_stall,
    output logic [NUM_BULK-1:0] ep_toggle,
    output logic [FADDR_W-1:0]  func_addr,
    output logic [NUM_BULK-1:0] int_en,
    output logic [NUM_BULK-1:0] int_req,
    output logic                usb_irq,
    output logic                req_to_cpu,
    output logic                pair_en,
    output logic                autovec_en,
    output logic                iso_send0,
    output logic [CFG_W-1:0]    cfg_num,
    output logic [CFG_W-1:0]    alt_set
);

    localparam int NUM_EP = NUM_BULK + NUM_ISO;

    logic                cpu_held;
    hs_e                 hs_code_e;
    logic [NUM_BULK-1:0] ack_mask;
    logic [NUM_BULK-1:0] in_take;
    logic [NUM_ISO-1:0]  iso_take;
    logic [NUM_ISO-1:0]  iso_loaded;
    mode_t               mode;

    usb_rst_cpu_hold u_hold (
        .clk         (clk),
        .por         (por),
        .host_wr     (host_ctl_wr),
        .host_val    (host_ctl_val),
        .eeprom_done (eeprom_done),
        .rom_strap   (rom_strap),
        .cpu_held    (cpu_held)
    );

    usb_rst_responder #(
        .NUM_BULK (NUM_BULK),
        .NUM_ISO  (NUM_ISO),
        .EP_W     (EP_W)
    ) u_resp (
        .clk        (clk),
        .por        (por),
        .cpu_held   (cpu_held),
        .tok_valid  (tok_valid),
        .tok_in     (tok_in),
        .tok_ep     (tok_ep),
        .ep_stall   (ep_stall),
        .in_armed   (in_armed),
        .iso_loaded (iso_loaded),
        .iso_send0  (mode.iso_send0),
        .hs_valid   (hs_valid),
        .hs_code    (hs_code_e),
        .ack_mask   (ack_mask),
        .in_take    (in_take),
        .iso_take   (iso_take)
    );

    usb_rst_ctrl_regs #(
        .NUM_BULK (NUM_BULK),
        .NUM_ISO  (NUM_ISO),
        .DATA_W   (DATA_W),
        .FADDR_W  (FADDR_W),
        .CFG_W    (CFG_W)
    ) u_regs (
        .clk        (clk),
        .por        (por),
        .cpu_held   (cpu_held),
        .cpu_wr     (cpu_wr),
        .cpu_waddr  (cpu_waddr),
        .cpu_wdata  (cpu_wdata),
        .ack_mask   (ack_mask),
        .in_take    (in_take),
        .iso_take   (iso_take),
        .in_armed   (in_armed),
        .ep_stall   (ep_stall),
        .ep_toggle  (ep_toggle),
        .int_en     (int_en),
        .int_req    (int_req),
        .iso_loaded (iso_loaded),
        .func_addr  (func_addr),
        .mode       (mode),
        .cfg_num    (cfg_num),
        .alt_set    (alt_set)
    );

    assign cpu_reset  = cpu_held;
    assign hs_code    = hs_code_e;
    assign out_ep_en  = {NUM_BULK{~cpu_held}};
    assign usb_irq    = |(int_req & int_en);
    assign req_to_cpu = mode.renum;
    assign pair_en    = mode.pairing;
    assign autovec_en = mode.autovec;
    assign iso_send0  = mode.iso_send0;

    // R7: OUT endpoints never enable while the CPU is held
    assert_out_gated_R7: assert property (@(posedge clk) disable iff (por)
        (out_ep_en != '0) |-> !cpu_reset);

    // R13: interrupt line goes quiet once all requests are cleared
    assert_irq_quiet_R13: assert property (@(posedge clk) disable iff (por)
        (int_req == '0) |-> !usb_irq);

    initial begin
        assert (NUM_EP <= (1 << EP_W) && NUM_BULK <= DATA_W && NUM_ISO <= DATA_W
                && 2*CFG_W <= DATA_W && FADDR_W <= DATA_W)
            else $error("usb_rst_seq parameter set out of range");
    end

endmodule

// File: tb/usb_rst_seq_tb.sv
`timescale 1ns/1ps
module usb_rst_seq_tb;

    localparam int NB = 8;
    localparam int NI = 8;

    logic       clk = 1'b0;
    logic       por, host_ctl_wr, host_ctl_val, eeprom_done, rom_strap;
    logic       tok_valid, tok_in, cpu_wr;
    logic [3:0] tok_ep, cpu_waddr;
    logic [7:0] cpu_wdata;
    logic       cpu_reset, hs_valid, usb_irq, req_to_cpu, pair_en, autovec_en, iso_send0;
    logic [1:0] hs_code;
    logic [7:0] out_ep_en, in_armed, ep_stall, ep_toggle, int_en, int_req;
    logic [6:0] func_addr;
    logic [3:0] cfg_num, alt_set;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model state
    int         m_st;   // 0 boot, 1 held, 2 run
    logic [7:0] m_arm, m_stall, m_tog, m_ien, m_ireq, m_iso;
    logic [6:0] m_faddr;
    logic [3:0] m_mode, m_cfg, m_alt;
    logic       m_hsv;
    logic [1:0] m_hs;

    usb_rst_seq u_dut (
        .clk(clk), .por(por), .host_ctl_wr(host_ctl_wr), .host_ctl_val(host_ctl_val),
        .eeprom_done(eeprom_done), .rom_strap(rom_strap), .tok_valid(tok_valid),
        .tok_in(tok_in), .tok_ep(tok_ep), .cpu_wr(cpu_wr), .cpu_waddr(cpu_waddr),
        .cpu_wdata(cpu_wdata), .cpu_reset(cpu_reset), .hs_valid(hs_valid),
        .hs_code(hs_code), .out_ep_en(out_ep_en), .in_armed(in_armed),
        .ep_stall(ep_stall), .ep_toggle(ep_toggle), .func_addr(func_addr),
        .int_en(int_en), .int_req(int_req), .usb_irq(usb_irq), .req_to_cpu(req_to_cpu),
        .pair_en(pair_en), .autovec_en(autovec_en), .iso_send0(iso_send0),
        .cfg_num(cfg_num), .alt_set(alt_set)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        host_ctl_wr = 0; host_ctl_val = 0; eeprom_done = 0;
        tok_valid = 0; tok_in = 0; tok_ep = 0;
        cpu_wr = 0; cpu_waddr = 0; cpu_wdata = 0;
    endtask

    // Next model state from the requirements, using pre-edge values
    task automatic model_step();
        logic held;
        logic [7:0] b;
        int e;
        if (por) begin
            m_st = 0; m_arm = 0; m_stall = 0; m_tog = 0; m_ien = 0; m_ireq = 0;
            m_iso = 0; m_faddr = 0; m_mode = 0; m_cfg = 0; m_alt = 0;
            m_hsv = 0; m_hs = 2'b00;
            return;
        end
        held  = (m_st != 2);
        m_hsv = tok_valid;
        m_hs  = 2'b00;
        if (tok_valid) begin
            e = int'(tok_ep);
            if (e < NB) begin
                b = 8'(1 << e);
                if (held)                m_hs = 2'b01;
                else if (m_stall[e])     m_hs = 2'b11;
                else if (tok_in)         m_hs = m_arm[e] ? 2'b10 : 2'b01;
                else                     m_hs = 2'b10;
                if (m_hs == 2'b10) begin
                    m_tog  = m_tog ^ b;
                    m_ireq = m_ireq | b;
                    if (tok_in) m_arm = m_arm & ~b;
                end
            end else if (e < NB + NI) begin
                b = 8'(1 << (e - NB));
                if (tok_in) begin
                    if (m_iso[e-NB]) begin m_hs = 2'b10; m_iso = m_iso & ~b; end
                    else if (m_mode[3]) m_hs = 2'b10;
                end
            end
        end
        if (cpu_wr && !held) begin
            case (cpu_waddr)
                4'd0: m_arm   = m_arm | cpu_wdata;
                4'd1: m_stall = cpu_wdata;
                4'd2: m_tog   = m_tog & ~cpu_wdata;
                4'd3: m_faddr = cpu_wdata[6:0];
                4'd4: m_ien   = cpu_wdata;
                4'd5: m_ireq  = m_ireq & ~cpu_wdata;
                4'd6: m_mode  = cpu_wdata[3:0];
                4'd7: begin m_cfg = cpu_wdata[3:0]; m_alt = cpu_wdata[7:4]; end
                4'd8: m_iso   = m_iso | cpu_wdata;
                default: ;
            endcase
        end
        case (m_st)
            0: m_st = host_ctl_wr ? (host_ctl_val ? 1 : 2) : ((rom_strap || eeprom_done) ? 2 : 1);
            1: m_st = host_ctl_wr ? (host_ctl_val ? 1 : 2) : (eeprom_done ? 2 : 1);
            default: m_st = (host_ctl_wr && host_ctl_val) ? 1 : 2;
        endcase
    endtask

    task automatic check_all(input string req);
        chk(req, "cpu_reset", cpu_reset, (m_st != 2));
        chk(req, "out_ep_en", out_ep_en, (m_st == 2) ? 8'hFF : 8'h00);
        chk(req, "hs_valid", hs_valid, m_hsv);
        chk(req, "hs_code", hs_code, m_hs);
        chk(req, "in_armed", in_armed, m_arm);
        chk(req, "ep_stall", ep_stall, m_stall);
        chk(req, "ep_toggle", ep_toggle, m_tog);
        chk(req, "func_addr", func_addr, m_faddr);
        chk(req, "int_en", int_en, m_ien);
        chk(req, "int_req", int_req, m_ireq);
        chk(req, "usb_irq", usb_irq, |(m_ireq & m_ien));
        chk(req, "req_to_cpu", req_to_cpu, m_mode[0]);
        chk(req, "pair_en", pair_en, m_mode[1]);
        chk(req, "autovec_en", autovec_en, m_mode[2]);
        chk(req, "iso_send0", iso_send0, m_mode[3]);
        chk(req, "cfg_num", cfg_num, m_cfg);
        chk(req, "alt_set", alt_set, m_alt);
    endtask

    // Inputs are set just after a falling edge; one rising edge; check at next fall
    task automatic step(input string req);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(req);
        idle_inputs();
    endtask

    task automatic token(input string req, input logic dir_in, input int ep, input logic [1:0] exp_hs);
        tok_valid = 1; tok_in = dir_in; tok_ep = 4'(ep);
        step(req);
        chk(req, "directed hs_code", hs_code, exp_hs);
    endtask

    task automatic cpu_write(input string req, input int addr, input logic [7:0] d);
        cpu_wr = 1; cpu_waddr = 4'(addr); cpu_wdata = d;
        step(req);
    endtask

    task automatic do_por(input logic strap);
        rom_strap = strap; por = 1;
        step("R1"); step("R1");
        por = 0;
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog R8 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        por = 1; rom_strap = 0;
        @(negedge clk);
        do_por(1'b0);
        // R1: start-up values
        chk("R1", "cpu_reset at por", cpu_reset, 1);
        chk("R1", "func_addr at por", func_addr, 0);
        chk("R1", "req_to_cpu at por", req_to_cpu, 0);
        step("R1");                       // boot cycle, strap low -> held
        chk("R2", "held without strap", cpu_reset, 1);

        // R6: held CPU gets NAK and ignores writes
        token("R6", 1'b1, 2, 2'b01);
        token("R6", 1'b0, 0, 2'b01);
        cpu_write("R6", 3, 8'h2A);
        chk("R6", "func_addr after held write", func_addr, 0);
        chk("R7", "out_ep_en while held", out_ep_en, 8'h00);
        rom_strap = 1; step("R2");
        chk("R2", "strap ignored after boot", cpu_reset, 1);
        rom_strap = 0;

        // R4: EEPROM release
        eeprom_done = 1; step("R4");
        chk("R4", "released by eeprom", cpu_reset, 0);
        chk("R7", "out_ep_en after release", out_ep_en, 8'hFF);

        // R11 and R9
        cpu_write("R11", 3, 8'h55);
        chk("R11", "func_addr", func_addr, 7'h55);
        cpu_write("R11", 7, 8'h21);
        chk("R11", "cfg/alt", {alt_set, cfg_num}, 8'h21);
        cpu_write("R11", 0, 8'h08);
        token("R9", 1'b1, 3, 2'b10);
        chk("R9", "toggle flip", ep_toggle, 8'h08);
        chk("R9", "disarmed", in_armed, 8'h00);
        token("R9", 1'b1, 3, 2'b01);
        cpu_write("R11", 1, 8'h02);
        token("R9", 1'b0, 1, 2'b11);
        token("R9", 1'b0, 0, 2'b10);
        chk("R9", "int_req set", int_req, 8'h09);
        cpu_write("R13", 4, 8'h08);
        chk("R13", "irq on", usb_irq, 1);
        cpu_write("R14", 5, 8'h08);
        chk("R14", "int_req cleared", int_req, 8'h01);
        chk("R13", "irq off", usb_irq, 0);
        cpu_write("R14", 2, 8'hFF);
        chk("R14", "toggles cleared", ep_toggle, 8'h00);

        // R10: isochronous no-load policy
        token("R10", 1'b1, 8, 2'b00);
        cpu_write("R10", 6, 8'h08);
        token("R10", 1'b1, 9, 2'b10);
        cpu_write("R10", 6, 8'h00);
        cpu_write("R10", 8, 8'h01);
        token("R10", 1'b1, 8, 2'b10);
        token("R10", 1'b1, 8, 2'b00);
        token("R10", 1'b0, 9, 2'b00);

        // R12: request routing
        cpu_write("R12", 6, 8'h01);
        chk("R12", "req_to_cpu", req_to_cpu, 1);

        // R5 / R3
        eeprom_done = 1; step("R5");
        chk("R5", "eeprom no effect running", cpu_reset, 0);
        host_ctl_wr = 1; host_ctl_val = 1; step("R5");
        chk("R5", "rehold", cpu_reset, 1);
        chk("R7", "out_ep_en off again", out_ep_en, 8'h00);
        token("R6", 1'b1, 5, 2'b01);
        host_ctl_wr = 1; host_ctl_val = 0; eeprom_done = 1; step("R3");
        chk("R3", "host release", cpu_reset, 0);
        host_ctl_wr = 1; host_ctl_val = 1; eeprom_done = 1; step("R3");
        chk("R3", "host write beats eeprom", cpu_reset, 1);

        // R2: strap release at boot, then strap ignored after rehold
        do_por(1'b1);
        chk("R1", "func_addr cleared by por", func_addr, 0);
        step("R2");
        chk("R2", "strap release", cpu_reset, 0);
        host_ctl_wr = 1; host_ctl_val = 1; step("R2");
        step("R2");
        chk("R2", "strap level ignored", cpu_reset, 1);
        rom_strap = 0;
        host_ctl_wr = 1; host_ctl_val = 0; step("R3");

        // Random mix, checked every cycle against the model
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 50) begin
                tok_valid = 1; tok_in = 1'($urandom_range(0, 1));
                tok_ep = 4'($urandom_range(0, 15));
            end else if (r < 85) begin
                cpu_wr = 1; cpu_waddr = 4'($urandom_range(0, 9));
                cpu_wdata = 8'($urandom_range(0, 255));
            end else if (r < 88) begin
                host_ctl_wr = 1; host_ctl_val = 1'($urandom_range(0, 1));
            end else if (r < 92) begin
                eeprom_done = 1;
            end
            step("R8");
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule